// File: doc/BRIEF.md
# Dual-Order Reclamation Victim Selector

The block sits beside a storage block allocator that sends short writes to a small DRAM buffer and long writes to NAND update chain-blocks. It keeps two separate least-recently-used orders over the logical blocks. The short order ranks logical blocks by their latest short write, and so covers the data held in DRAM. The long order ranks the logical blocks that own a NAND update chain-block by their latest long write. Every write, reported on the write port, moves its logical block to the most-recent place in the order that matches its length class. A block not yet in that order joins it.

When the allocator runs out of DRAM blocks or of NAND chain-blocks, it raises the matching reclaim request. The block takes the least recently used member of the matching order as the victim. It then drives single-cycle command pulses to the data path and waits for a completion acknowledge after each one. A DRAM reclaim flushes the victim's DRAM data into NAND. If the acknowledge reports that the update chain-block filled during the flush, a merge is inserted and the flush is issued again. The DRAM blocks are then released. A NAND reclaim merges the update and data chain-blocks and then releases the update chain-block. When an update chain-block reports that it is full, a forced merge runs on that logical block whatever its recency. Each release removes the victim from the matching order, so it cannot be chosen again until it is written again.

Top module: `rcl_victim_sel`

## Requirements
- R1: After reset, busy, done and all command outputs are 0 and both orders are empty, so a reclaim ends with done_empty=1.
- R2: A DRAM reclaim (dram_rq) picks, among blocks with a short write (wr_valid with wr_long=0), the one whose latest short write is oldest. Each short write makes its block the most recent.
- R3: A NAND reclaim (nand_rq) picks, among blocks with a long write (wr_long=1), the one whose latest long write is oldest. Short writes do not change this order and long writes do not change the short order.
- R4: A NAND reclaim issues cmd_merge and then cmd_release with cmd_rel_dram=0, each after the acknowledge of the one before. It ends with done, done_kind=1, and removes the victim from the long order.
- R5: A DRAM reclaim issues cmd_flush and then cmd_release with cmd_rel_dram=1. It ends with done, done_kind=2, and removes the victim from the short order.
- R6: An acknowledge of cmd_flush with act_full=1 makes the next command cmd_merge, followed by a new cmd_flush, before the release.
- R7: full_valid with full_lb starts a forced merge on full_lb: cmd_merge, then cmd_release with cmd_rel_dram=0, then done with done_kind=0. full_lb leaves the long order, even when it is not the oldest member.
- R8: Requests are taken only while idle. When several are pending at once, the priority is full_valid, then nand_rq, then dram_rq.
- R9: A reclaim whose order is empty issues no command and ends with done and done_empty=1.
- R10: Commands are one-hot, each lasts exactly one cycle, and cmd_lb holds the victim for the whole job. act_ack counts only after a command has been issued.
- R11: If a write of the matching class to the victim arrives in the same cycle as the release acknowledge, the write wins. The victim stays in the order as the most recent member.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write to logical block wr_lb occurred |
| wr_long | input | 1 | 1 = long write (NAND), 0 = short write (DRAM) |
| wr_lb | input | IDX_W | Logical block of the write |
| dram_rq | input | 1 | DRAM pool exhausted; held until done with done_kind=2 |
| nand_rq | input | 1 | NAND pool exhausted; held until done with done_kind=1 |
| full_valid | input | 1 | Update chain-block of full_lb is full; held until done with done_kind=0 |
| full_lb | input | IDX_W | Logical block whose update chain-block filled |
| act_ack | input | 1 | Completion of the outstanding command |
| act_full | input | 1 | With a flush acknowledge: the update chain-block filled |
| cmd_flush | output | 1 | Pulse: move DRAM data of cmd_lb into NAND |
| cmd_merge | output | 1 | Pulse: merge update and data chain-blocks of cmd_lb |
| cmd_release | output | 1 | Pulse: return the freed blocks of cmd_lb to their pool |
| cmd_rel_dram | output | 1 | With cmd_release: 1 = DRAM blocks, 0 = update chain-block |
| cmd_lb | output | IDX_W | Victim logical block of the current or last job |
| busy | output | 1 | A job is in progress |
| done | output | 1 | Pulse: job finished |
| done_kind | output | 2 | Job kind: 0 forced merge, 1 NAND reclaim, 2 DRAM reclaim |
| done_empty | output | 1 | With done: no candidate existed |

## Verification
The bench builds overlapping short and long write histories and then drains both orders alternately. A design that shares one recency order, or that updates the wrong order, names the wrong victim or ends a drain early. Separate tests acknowledge a flush with the full flag, raise all three requests in the same cycle, and land a write on the victim in the cycle of its release acknowledge. A design that skips the inserted merge, that grants in the wrong order, or that lets the removal win would show a different command sequence or a different later victim. Forced merges on a block that is not the oldest, reclaims from empty orders, and a reset in the middle of a history check removal and clearing. Pulse width and one-hotness are also checked on every command.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SELECT, S_FLUSH, S_MERGE, S_RELEASE, S_DONE
  } rcl_state_t;

  typedef enum logic [1:0] {
    JOB_FORCE = 2'd0,
    JOB_NAND  = 2'd1,
    JOB_DRAM  = 2'd2
  } rcl_job_t;
endpackage

// File: rtl/rcl_recency_order.sv
module rcl_recency_order #(
  parameter int N_ENT = 8,
  parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             drop_en,
  input  logic [IDX_W-1:0] drop_idx,
  output logic             cand_valid,
  output logic [IDX_W-1:0] cand_idx
);
  // Ages of members form a permutation of 0..members-1; oldest = largest.
  localparam int AGE_W = IDX_W;

  logic [N_ENT-1:0] mem_q, mem_d;
  logic [AGE_W-1:0] age_q [N_ENT];
  logic [AGE_W-1:0] age_d [N_ENT];
  logic             upd_en;
  logic             t_in, d_live;
  logic [AGE_W-1:0] t_age, d_age;
  logic             inc, dec;
  logic [AGE_W-1:0] best_age;

  assign upd_en = touch_en | drop_en;

  always_comb begin
    t_in   = mem_q[touch_idx];
    t_age  = age_q[touch_idx];
    d_age  = age_q[drop_idx];
    d_live = drop_en && mem_q[drop_idx] && !(touch_en && (touch_idx == drop_idx));
    mem_d  = mem_q;
    for (int i = 0; i < N_ENT; i++) begin
      inc = touch_en && mem_q[i] && (IDX_W'(i) != touch_idx) && (!t_in || (age_q[i] < t_age));
      dec = d_live && mem_q[i] && (age_q[i] > d_age);
      age_d[i] = age_q[i] + {{(AGE_W-1){1'b0}}, inc} - {{(AGE_W-1){1'b0}}, dec};
      if (touch_en && (IDX_W'(i) == touch_idx)) begin
        mem_d[i] = 1'b1;
        age_d[i] = '0;
      end else if (d_live && (IDX_W'(i) == drop_idx)) begin
        mem_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      for (int i = 0; i < N_ENT; i++) age_q[i] <= '0;
    end else if (upd_en) begin
      mem_q <= mem_d;
      for (int i = 0; i < N_ENT; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    cand_valid = 1'b0;
    cand_idx   = '0;
    best_age   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (mem_q[i] && (!cand_valid || (age_q[i] > best_age))) begin
        cand_valid = 1'b1;
        cand_idx   = IDX_W'(i);
        best_age   = age_q[i];
      end
    end
  end
endmodule

// File: rtl/rcl_seq_fsm.sv
module rcl_seq_fsm
  import rcl_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dram_rq,
  input  logic             nand_rq,
  input  logic             full_valid,
  input  logic [IDX_W-1:0] full_lb,
  input  logic             dram_cand_v,
  input  logic [IDX_W-1:0] dram_cand,
  input  logic             nand_cand_v,
  input  logic [IDX_W-1:0] nand_cand,
  input  logic             act_ack,
  input  logic             act_full,
  output logic             cmd_flush,
  output logic             cmd_merge,
  output logic             cmd_release,
  output logic             cmd_rel_dram,
  output logic [IDX_W-1:0] cmd_lb,
  output logic             busy,
  output logic             done,
  output logic [1:0]       done_kind,
  output logic             done_empty,
  output logic [1:0]       drop_en,
  output rcl_job_t         job_o
);
  rcl_state_t       st_q, st_d;
  rcl_job_t         job_q, job_d;
  logic [IDX_W-1:0] lb_q, lb_d;
  logic             emp_q, emp_d;
  logic             wait_q, wait_d;
  logic             rel_acc;

  always_comb begin
    st_d   = st_q;
    job_d  = job_q;
    lb_d   = lb_q;
    emp_d  = emp_q;
    wait_d = wait_q;
    case (st_q)
      S_IDLE: begin
        wait_d = 1'b0;
        emp_d  = 1'b0;
        if (full_valid) begin
          job_d = JOB_FORCE;
          lb_d  = full_lb;
          st_d  = S_SELECT;
        end else if (nand_rq) begin
          job_d = JOB_NAND;
          st_d  = S_SELECT;
        end else if (dram_rq) begin
          job_d = JOB_DRAM;
          st_d  = S_SELECT;
        end
      end
      S_SELECT: begin
        case (job_q)
          JOB_FORCE: st_d = S_MERGE;
          JOB_NAND: begin
            if (nand_cand_v) begin
              lb_d = nand_cand;
              st_d = S_MERGE;
            end else begin
              emp_d = 1'b1;
              st_d  = S_DONE;
            end
          end
          default: begin
            if (dram_cand_v) begin
              lb_d = dram_cand;
              st_d = S_FLUSH;
            end else begin
              emp_d = 1'b1;
              st_d  = S_DONE;
            end
          end
        endcase
      end
      S_FLUSH: begin
        if (!wait_q) wait_d = 1'b1;
        else if (act_ack) begin
          wait_d = 1'b0;
          st_d   = act_full ? S_MERGE : S_RELEASE;
        end
      end
      S_MERGE: begin
        if (!wait_q) wait_d = 1'b1;
        else if (act_ack) begin
          wait_d = 1'b0;
          st_d   = (job_q == JOB_DRAM) ? S_FLUSH : S_RELEASE;
        end
      end
      S_RELEASE: begin
        if (!wait_q) wait_d = 1'b1;
        else if (act_ack) begin
          wait_d = 1'b0;
          st_d   = S_DONE;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      job_q  <= JOB_FORCE;
      lb_q   <= '0;
      emp_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      job_q  <= job_d;
      lb_q   <= lb_d;
      emp_q  <= emp_d;
      wait_q <= wait_d;
    end
  end

  assign cmd_flush    = (st_q == S_FLUSH)   && !wait_q;
  assign cmd_merge    = (st_q == S_MERGE)   && !wait_q;
  assign cmd_release  = (st_q == S_RELEASE) && !wait_q;
  assign cmd_rel_dram = cmd_release && (job_q == JOB_DRAM);
  assign cmd_lb       = lb_q;
  assign busy         = (st_q != S_IDLE);
  assign done         = (st_q == S_DONE);
  assign done_kind    = job_q;
  assign done_empty   = done && emp_q;
  assign job_o        = job_q;

  assign rel_acc    = (st_q == S_RELEASE) && wait_q && act_ack;
  assign drop_en[0] = rel_acc && (job_q == JOB_DRAM);
  assign drop_en[1] = rel_acc && (job_q != JOB_DRAM);
endmodule

// File: rtl/rcl_victim_sel.sv
module rcl_victim_sel
  import rcl_pkg::*;
#(
  parameter int N_LB  = 8,
  parameter int IDX_W = (N_LB > 1) ? $clog2(N_LB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_long,
  input  logic [IDX_W-1:0] wr_lb,
  input  logic             dram_rq,
  input  logic             nand_rq,
  input  logic             full_valid,
  input  logic [IDX_W-1:0] full_lb,
  input  logic             act_ack,
  input  logic             act_full,
  output logic             cmd_flush,
  output logic             cmd_merge,
  output logic             cmd_release,
  output logic             cmd_rel_dram,
  output logic [IDX_W-1:0] cmd_lb,
  output logic             busy,
  output logic             done,
  output logic [1:0]       done_kind,
  output logic             done_empty
);
  localparam int N_ORD = 2;  // 0: short-write order, 1: long-write order

  logic [1:0]       rst_sync_q;
  logic             rst_core;
  logic [N_ORD-1:0] cand_v;
  logic [IDX_W-1:0] cand_i [N_ORD];
  logic [N_ORD-1:0] drop_en;
  rcl_job_t         job_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core = rst_sync_q[1];

  for (genvar g = 0; g < N_ORD; g++) begin : g_ord
    logic t_en;
    assign t_en = wr_valid && (wr_long == 1'(g));
    rcl_recency_order #(.N_ENT(N_LB), .IDX_W(IDX_W)) u_ord (
      .clk       (clk),
      .rst_n     (rst_core),
      .touch_en  (t_en),
      .touch_idx (wr_lb),
      .drop_en   (drop_en[g]),
      .drop_idx  (cmd_lb),
      .cand_valid(cand_v[g]),
      .cand_idx  (cand_i[g])
    );
  end

  rcl_seq_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_core),
    .dram_rq     (dram_rq),
    .nand_rq     (nand_rq),
    .full_valid  (full_valid),
    .full_lb     (full_lb),
    .dram_cand_v (cand_v[0]),
    .dram_cand   (cand_i[0]),
    .nand_cand_v (cand_v[1]),
    .nand_cand   (cand_i[1]),
    .act_ack     (act_ack),
    .act_full    (act_full),
    .cmd_flush   (cmd_flush),
    .cmd_merge   (cmd_merge),
    .cmd_release (cmd_release),
    .cmd_rel_dram(cmd_rel_dram),
    .cmd_lb      (cmd_lb),
    .busy        (busy),
    .done        (done),
    .done_kind   (done_kind),
    .done_empty  (done_empty),
    .drop_en     (drop_en),
    .job_o       (job_w)
  );
endmodule

// File: rtl/rcl_victim_sel_chk.sv
module rcl_victim_sel_chk
  import rcl_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             full_valid,
  input logic             cmd_flush,
  input logic             cmd_merge,
  input logic             cmd_release,
  input logic [IDX_W-1:0] cmd_lb,
  input rcl_job_t         job
);
  p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_flush, cmd_merge, cmd_release}));

  p_merge_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_merge |=> !cmd_merge);

  p_flush_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> !cmd_flush);

  p_victim_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_release |-> $stable(cmd_lb));

  p_flush_dram_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |-> (job == JOB_DRAM));

  p_force_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && full_valid) |=> (job == JOB_FORCE));

  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind rcl_victim_sel rcl_victim_sel_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core),
  .busy       (busy),
  .done       (done),
  .full_valid (full_valid),
  .cmd_flush  (cmd_flush),
  .cmd_merge  (cmd_merge),
  .cmd_release(cmd_release),
  .cmd_lb     (cmd_lb),
  .job        (job_w)
);

// File: tb/rcl_victim_sel_tb.sv
`timescale 1ns/1ps
module rcl_victim_sel_tb;
  localparam int N_LB  = 8;
  localparam int IDX_W = 3;
  localparam int N_VEC = 16;
  // {empty, op[1:0], lb[2:0], exp_lb[2:0]}; op 0 short wr, 1 long wr, 2 DRAM reclaim, 3 NAND reclaim
  localparam logic [8:0] VEC [N_VEC] = '{
    {1'b0, 2'd0, 3'd3, 3'd0}, {1'b0, 2'd0, 3'd5, 3'd0}, {1'b0, 2'd0, 3'd1, 3'd0},
    {1'b0, 2'd1, 3'd6, 3'd0}, {1'b0, 2'd1, 3'd2, 3'd0}, {1'b0, 2'd1, 3'd3, 3'd0},
    {1'b0, 2'd0, 3'd3, 3'd0}, {1'b0, 2'd1, 3'd6, 3'd0},
    {1'b0, 2'd2, 3'd0, 3'd5}, {1'b0, 2'd3, 3'd0, 3'd2}, {1'b0, 2'd2, 3'd0, 3'd1},
    {1'b0, 2'd3, 3'd0, 3'd3}, {1'b0, 2'd2, 3'd0, 3'd3}, {1'b1, 2'd2, 3'd0, 3'd0},
    {1'b0, 2'd3, 3'd0, 3'd6}, {1'b1, 2'd3, 3'd0, 3'd0}
  };

  logic clk = 1'b0;
  logic rst_n, wr_valid, wr_long, dram_rq, nand_rq, full_valid, act_ack, act_full;
  logic [IDX_W-1:0] wr_lb, full_lb, cmd_lb;
  logic cmd_flush, cmd_merge, cmd_release, cmd_rel_dram, busy, done, done_empty;
  logic [1:0] done_kind;

  int n_chk = 0, n_err = 0, pulse_err = 0;
  int r_seq, r_lb, r_kind, r_empty;
  bit r_same, r_timeout;

  always #2.5 clk = ~clk;

  rcl_victim_sel #(.N_LB(N_LB), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_long(wr_long), .wr_lb(wr_lb),
    .dram_rq(dram_rq), .nand_rq(nand_rq), .full_valid(full_valid), .full_lb(full_lb),
    .act_ack(act_ack), .act_full(act_full), .cmd_flush(cmd_flush), .cmd_merge(cmd_merge),
    .cmd_release(cmd_release), .cmd_rel_dram(cmd_rel_dram), .cmd_lb(cmd_lb), .busy(busy),
    .done(done), .done_kind(done_kind), .done_empty(done_empty)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_lb(input bit lng, input int lb);
    @(negedge clk);
    wr_valid = 1'b1; wr_long = lng; wr_lb = IDX_W'(lb);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Serves commands with a one-cycle-late acknowledge; seq codes: flush 1, merge 2, release DRAM 3, release update 4
  task automatic run_job(input bit full_once, input bit touch_rel, input bit touch_long);
    bit ack_next = 0, full_next = 0, used = 0, rel_next = 0;
    int first_lb = -1;
    logic [2:0] cur, prev = 3'b000;
    r_seq = 0; r_same = 1; r_timeout = 1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      act_ack = 1'b0; act_full = 1'b0; wr_valid = 1'b0;
      cur = {cmd_flush, cmd_merge, cmd_release};
      if (cur != 3'b000 && prev != 3'b000) pulse_err++;
      if ($countones(cur) > 1) pulse_err++;
      if (ack_next) begin
        act_ack = 1'b1; act_full = full_next;
        if (rel_next && touch_rel) begin
          wr_valid = 1'b1; wr_long = touch_long; wr_lb = cmd_lb;
        end
        ack_next = 0;
      end
      if (cur != 3'b000) begin
        r_seq = r_seq * 10 + (cmd_flush ? 1 : cmd_merge ? 2 : cmd_rel_dram ? 3 : 4);
        if (first_lb < 0) first_lb = int'(cmd_lb);
        else if (int'(cmd_lb) != first_lb) r_same = 0;
        ack_next = 1;
        full_next = cmd_flush && full_once && !used;
        if (full_next) used = 1;
        rel_next = cmd_release;
      end
      prev = cur;
      if (done) begin
        r_kind = int'(done_kind); r_empty = int'(done_empty); r_lb = int'(cmd_lb);
        if (done_kind == 2'd0) full_valid = 1'b0;
        else if (done_kind == 2'd1) nand_rq = 1'b0;
        else dram_rq = 1'b0;
        r_timeout = 0;
        break;
      end
    end
    act_ack = 1'b0; act_full = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic check_job(input string req, input int e_seq, input int e_lb, input int e_kind, input int e_empty);
    check(!r_timeout, req, "job finished", int'(r_timeout), 0);
    check(r_seq == e_seq, req, "command sequence", r_seq, e_seq);
    check(r_kind == e_kind, req, "done_kind", r_kind, e_kind);
    check(r_empty == e_empty, req, "done_empty", r_empty, e_empty);
    if (e_empty == 0) begin
      check(r_lb == e_lb, req, "victim", r_lb, e_lb);
      check(r_same, req, "victim stable over job", int'(r_same), 1);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(60000 * 5);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wr_valid = 0; wr_long = 0; wr_lb = '0; dram_rq = 0; nand_rq = 0;
    full_valid = 0; full_lb = '0; act_ack = 0; act_full = 0;
    do_reset();
    // R1: reset state
    check({busy, done, cmd_flush, cmd_merge, cmd_release} == 5'b0, "R1", "outputs after reset",
          int'({busy, done, cmd_flush, cmd_merge, cmd_release}), 0);

    // Table walk: R2, R3, R4, R5, R9
    for (int v = 0; v < N_VEC; v++) begin
      case (VEC[v][7:6])
        2'd0: write_lb(1'b0, int'(VEC[v][5:3]));
        2'd1: write_lb(1'b1, int'(VEC[v][5:3]));
        2'd2: begin
          @(negedge clk); dram_rq = 1'b1;
          run_job(0, 0, 0);
          if (VEC[v][8]) check_job("R9", 0, 0, 2, 1);
          else           check_job("R2 R5", 13, int'(VEC[v][2:0]), 2, 0);
        end
        default: begin
          @(negedge clk); nand_rq = 1'b1;
          run_job(0, 0, 0);
          if (VEC[v][8]) check_job("R9", 0, 0, 1, 1);
          else           check_job("R3 R4", 24, int'(VEC[v][2:0]), 1, 0);
        end
      endcase
    end

    // R6: full flag on flush inserts a merge and a second flush
    write_lb(1'b0, 4);
    @(negedge clk); dram_rq = 1'b1;
    run_job(1, 0, 0);
    check_job("R6", 1213, 4, 2, 0);

    // R7: forced merge on the younger member, then it is gone from the long order
    write_lb(1'b1, 0);
    write_lb(1'b1, 1);
    @(negedge clk); full_valid = 1'b1; full_lb = 3'd1;
    run_job(0, 0, 0);
    check_job("R7", 24, 1, 0, 0);
    @(negedge clk); nand_rq = 1'b1;
    run_job(0, 0, 0);
    check_job("R7", 24, 0, 1, 0);
    @(negedge clk); nand_rq = 1'b1;
    run_job(0, 0, 0);
    check_job("R7", 0, 0, 1, 1);

    // R8: all three requests raised together
    write_lb(1'b0, 2);
    write_lb(1'b1, 7);
    @(negedge clk); full_valid = 1'b1; full_lb = 3'd5; nand_rq = 1'b1; dram_rq = 1'b1;
    run_job(0, 0, 0);
    check_job("R8", 24, 5, 0, 0);
    run_job(0, 0, 0);
    check_job("R8", 24, 7, 1, 0);
    run_job(0, 0, 0);
    check_job("R8", 13, 2, 2, 0);

    // R11: short write to the victim in its release-ack cycle keeps it
    write_lb(1'b0, 6);
    @(negedge clk); dram_rq = 1'b1;
    run_job(0, 1, 0);
    check_job("R11", 13, 6, 2, 0);
    @(negedge clk); dram_rq = 1'b1;
    run_job(0, 0, 0);
    check_job("R11", 13, 6, 2, 0);
    @(negedge clk); dram_rq = 1'b1;
    run_job(0, 0, 0);
    check_job("R11", 0, 0, 2, 1);

    // R1: reset mid-history clears the orders
    write_lb(1'b0, 4);
    write_lb(1'b1, 4);
    do_reset();
    @(negedge clk); dram_rq = 1'b1;
    run_job(0, 0, 0);
    check_job("R1", 0, 0, 2, 1);
    @(negedge clk); nand_rq = 1'b1;
    run_job(0, 0, 0);
    check_job("R1", 0, 0, 1, 1);

    // R10: pulse width and one-hot seen over every job
    check(pulse_err == 0, "R10", "pulse violations", pulse_err, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule